// File: doc/BRIEF.md
# External Data Address Generator

This block turns a move-external instruction from a small microcontroller core into a 16-bit address and the strobes for the external data memory bus. It keeps two 16-bit data pointers, a one-bit pointer select and an 8-bit page register. In paged register-indirect mode the page register gives the high byte and the core's working register (R0 or R1 of the current bank, passed in as `workReg`) gives the low byte. In pointer mode the active pointer gives the whole address. The paged form can reach every 256-byte page of the 64 KB space without touching either pointer.

The core sets up the registers through a byte-wide special-function-register port. It issues one operation per cycle on `opKind` and gets read results back two cycles later. The address is decoded into three regions: shared volatile data RAM starting at zero, a 2 KB hardware configuration RAM and a 128-byte battery-backed configuration RAM. An access that falls outside all three raises a flag and never reaches the memory. A read from such an address returns zero.

Top module: `xdata_addr_gen`

## Requirements
- R1: After reset both pointers, the page register and the select bit are zero, so every register byte reads 0x00 and no memory strobe or result is active.
- R2: For opKind 1 (paged read) and 2 (paged write) the address is {page register, workReg}. The page register is written and read at register address 0xBF.
- R3: For opKind 3 (pointer read) and 4 (pointer write) the address is the full 16-bit value of the active pointer.
- R4: Bit 0 of register address 0x92 selects the active pointer: 0 gives the primary pointer and 1 the secondary one. The other bits of that register are ignored on write and read back as 0.
- R5: Writing the select bit leaves the contents of both pointers unchanged.
- R6: opKind 5 loads `loadValue` and opKind 6 adds one, wrapping 0xFFFF to 0x0000. Both act only on the active pointer, and the other pointer keeps its value.
- R7: Register addresses 0x82 (low byte) and 0x83 (high byte) read and write only the active pointer.
- R8: `memRegion` codes the decoded address: 1 for 0x0000 up to SHARED_BYTES-1, 2 for 0x2000–0x27FF, 3 for 0x2800–0x287F and 0 for any other address.
- R9: An access to region 0 raises `unmappedFlag` in the operation cycle, keeps `memWe` and `memRe` low, and a read of that kind returns 0x00.
- R10: A mapped write raises `memWe` for exactly the operation cycle, with `memAddr` and `memWdata` valid in that same cycle.
- R11: A mapped read raises `memRe` in the operation cycle. The memory returns its byte in the next cycle, and `loadValid` is high for one cycle, the second cycle after the operation, with `loadData` holding that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrWe | input | 1 | Register write enable |
| sfrAddr | input | 8 | Register address |
| sfrWdata | input | 8 | Register write data |
| sfrRdata | output | 8 | Register read data, combinational from sfrAddr |
| opKind | input | 3 | Operation code: 0 idle, 1 paged read, 2 paged write, 3 pointer read, 4 pointer write, 5 pointer load, 6 pointer increment |
| workReg | input | 8 | Working-register value used as the low byte in paged mode |
| loadValue | input | 16 | Value for pointer load |
| storeData | input | 8 | Byte to write to memory |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memRdata | input | 8 | Memory read data, valid the cycle after memRe |
| memRegion | output | 2 | Decoded region code |
| unmappedFlag | output | 1 | Access to an undecoded address |
| loadData | output | 8 | Read result |
| loadValid | output | 1 | Read result valid |

## Verification
The bench builds the block with its default parameters: two pointers, 16-bit addresses, byte data and a 3 KB shared RAM. With a 3 KB shared RAM, the byte at 0x0BFF is the last mapped shared byte and 0x0C00 falls into the unmapped gap. The pointer-increment test steps across exactly that edge, and also across the last battery-backed byte at 0x287F. The same settings put the 0xFFFF wrap and the behaviour when the select bit is toggled within a few operations of reset.

// File: rtl/xag_pkg.sv
package xag_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PG_RD   = 3'd1,
    OP_PG_WR   = 3'd2,
    OP_PT_RD   = 3'd3,
    OP_PT_WR   = 3'd4,
    OP_PT_LOAD = 3'd5,
    OP_PT_INC  = 3'd6
  } opKind_e;

  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_SHARED = 2'd1,
    REG_CFG    = 2'd2,
    REG_BATT   = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_PAGE = 3'd1,
    RD_SEL  = 3'd2,
    RD_LO   = 3'd3,
    RD_HI   = 3'd4
  } rdSrc_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic   memRd;
    logic   memWr;
    logic   usePaged;
    logic   ptrLoad;
    logic   ptrInc;
    logic   ptrLoWr;
    logic   ptrHiWr;
    logic   pageWr;
    logic   selWr;
    rdSrc_e rdSrc;
  } ctrlStrobes_t;

endpackage

// File: rtl/xag_ctrl.sv
module xag_ctrl
  import xag_pkg::*;
#(
  parameter int                SFR_AW     = 8,
  parameter logic [SFR_AW-1:0] PAGE_SFR   = 8'hBF,
  parameter logic [SFR_AW-1:0] SEL_SFR    = 8'h92,
  parameter logic [SFR_AW-1:0] PTR_LO_SFR = 8'h82,
  parameter logic [SFR_AW-1:0] PTR_HI_SFR = 8'h83
) (
  input  logic              sfrWe,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [2:0]        opKind,
  output ctrlStrobes_t      strb
);

  opKind_e opCode;
  assign opCode = opKind_e'(opKind);

  always_comb begin
    strb = '0;
    strb.rdSrc = RD_NONE;
    case (opCode)
      OP_PG_RD:   begin strb.memRd = 1'b1; strb.usePaged = 1'b1; end
      OP_PG_WR:   begin strb.memWr = 1'b1; strb.usePaged = 1'b1; end
      OP_PT_RD:   strb.memRd   = 1'b1;
      OP_PT_WR:   strb.memWr   = 1'b1;
      OP_PT_LOAD: strb.ptrLoad = 1'b1;
      OP_PT_INC:  strb.ptrInc  = 1'b1;
      default:    ;
    endcase

    if (sfrWe) begin
      strb.pageWr  = (sfrAddr == PAGE_SFR);
      strb.selWr   = (sfrAddr == SEL_SFR);
      strb.ptrLoWr = (sfrAddr == PTR_LO_SFR);
      strb.ptrHiWr = (sfrAddr == PTR_HI_SFR);
    end

    if      (sfrAddr == PAGE_SFR)   strb.rdSrc = RD_PAGE;
    else if (sfrAddr == SEL_SFR)    strb.rdSrc = RD_SEL;
    else if (sfrAddr == PTR_LO_SFR) strb.rdSrc = RD_LO;
    else if (sfrAddr == PTR_HI_SFR) strb.rdSrc = RD_HI;
  end

endmodule

// File: rtl/xag_region_dec.sv
module xag_region_dec
  import xag_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int unsigned SHARED_BYTES = 3072,
  parameter int unsigned CFG_BASE     = 32'h2000,
  parameter int unsigned CFG_BYTES    = 2048,
  parameter int unsigned BATT_BASE    = 32'h2800,
  parameter int unsigned BATT_BYTES   = 128
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  localparam logic [31:0] CFG_END  = 32'(CFG_BASE + CFG_BYTES);
  localparam logic [31:0] BATT_END = 32'(BATT_BASE + BATT_BYTES);

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    if (a32 < 32'(SHARED_BYTES))
      region = REG_SHARED;
    else if (a32 >= 32'(CFG_BASE) && a32 < CFG_END)
      region = REG_CFG;
    else if (a32 >= 32'(BATT_BASE) && a32 < BATT_END)
      region = REG_BATT;
    else
      region = REG_NONE;
  end

endmodule

// File: rtl/xag_datapath.sv
module xag_datapath
  import xag_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_PTRS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] workReg,
  input  logic [ADDR_W-1:0] loadValue,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic [DATA_W-1:0] sfrRdata,
  input  region_e           region,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              unmappedFlag,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);

  localparam int SEL_W  = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1;
  localparam int PAGE_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ptrBank [NUM_PTRS];
  logic [SEL_W-1:0]  selQ;
  logic [PAGE_W-1:0] pageQ;
  logic [ADDR_W-1:0] ptrCur, ptrNext;
  logic              ptrTouch;
  logic              mapped;
  logic              rdPendQ, rdZeroQ;

  assign ptrCur = ptrBank[selQ];

  // Next value of the active pointer; only one source acts per cycle
  always_comb begin
    ptrNext  = ptrCur;
    ptrTouch = 1'b1;
    if (strb.ptrLoad)      ptrNext = loadValue;
    else if (strb.ptrInc)  ptrNext = ptrCur + ADDR_W'(1);
    else if (strb.ptrLoWr) ptrNext[DATA_W-1:0] = sfrWdata;
    else if (strb.ptrHiWr) ptrNext[ADDR_W-1:DATA_W] = sfrWdata[PAGE_W-1:0];
    else                   ptrTouch = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PTRS; i++) ptrBank[i] <= '0;
      selQ  <= '0;
      pageQ <= '0;
    end else begin
      if (ptrTouch)    ptrBank[selQ] <= ptrNext;
      if (strb.selWr)  selQ  <= sfrWdata[SEL_W-1:0];
      if (strb.pageWr) pageQ <= sfrWdata[PAGE_W-1:0];
    end
  end

  always_comb begin
    case (strb.rdSrc)
      RD_PAGE: sfrRdata = DATA_W'(pageQ);
      RD_SEL:  sfrRdata = DATA_W'(selQ);
      RD_LO:   sfrRdata = ptrCur[DATA_W-1:0];
      RD_HI:   sfrRdata = DATA_W'(ptrCur[ADDR_W-1:DATA_W]);
      default: sfrRdata = '0;
    endcase
  end

  // Address formation and memory strobes
  assign memAddr      = strb.usePaged ? {pageQ, workReg} : ptrCur;
  assign memWdata     = storeData;
  assign mapped       = (region != REG_NONE);
  assign memWe        = strb.memWr & mapped;
  assign memRe        = strb.memRd & mapped;
  assign unmappedFlag = (strb.memRd | strb.memWr) & ~mapped;

  // Read return: memory answers one cycle after memRe, captured then
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPendQ   <= 1'b0;
      rdZeroQ   <= 1'b0;
      loadValid <= 1'b0;
      loadData  <= '0;
    end else begin
      rdPendQ   <= strb.memRd;
      rdZeroQ   <= strb.memRd & ~mapped;
      loadValid <= rdPendQ;
      if (rdPendQ) loadData <= rdZeroQ ? '0 : memRdata;
    end
  end

  // Read result arrives exactly two cycles after a mapped read strobe
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(memRe, 2) |-> loadValid);

  // An unmapped read returns zero two cycles later
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(unmappedFlag && strb.memRd, 2) |-> (loadValid && loadData == '0));

  for (genvar g = 0; g < NUM_PTRS; g++) begin : gPtrChk
    assert_sel_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strb.selWr && !ptrTouch) |=> $stable(ptrBank[g]));

    assert_idle_ptr_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
      (ptrTouch && selQ != SEL_W'(g)) |=> $stable(ptrBank[g]));

    assert_inc_wraps_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ptrInc && selQ == SEL_W'(g) && (&ptrBank[g])) |=> (ptrBank[g] == '0));
  end

endmodule

// File: rtl/xdata_addr_gen.sv
module xdata_addr_gen
  import xag_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          NUM_PTRS     = 2,
  parameter int unsigned SHARED_BYTES = 3072
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWe,
  input  logic [7:0]        sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic [DATA_W-1:0] sfrRdata,
  input  logic [2:0]        opKind,
  input  logic [DATA_W-1:0] workReg,
  input  logic [ADDR_W-1:0] loadValue,
  input  logic [DATA_W-1:0] storeData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [1:0]        memRegion,
  output logic              unmappedFlag,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);

  ctrlStrobes_t strb;
  region_e      region;

  xag_ctrl #(.SFR_AW(8)) uCtrl (
    .sfrWe  (sfrWe),
    .sfrAddr(sfrAddr),
    .opKind (opKind),
    .strb   (strb)
  );

  xag_region_dec #(.ADDR_W(ADDR_W), .SHARED_BYTES(SHARED_BYTES)) uDec (
    .addr  (memAddr),
    .region(region)
  );

  xag_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTRS(NUM_PTRS)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .workReg     (workReg),
    .loadValue   (loadValue),
    .storeData   (storeData),
    .sfrWdata    (sfrWdata),
    .sfrRdata    (sfrRdata),
    .region      (region),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memWe       (memWe),
    .memRe       (memRe),
    .memRdata    (memRdata),
    .unmappedFlag(unmappedFlag),
    .loadData    (loadData),
    .loadValid   (loadValid)
  );

  assign memRegion = region;

endmodule

// File: tb/xdata_addr_gen_test.sv
module xdata_addr_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sfrWe = 1'b0;
  logic [7:0]  sfrAddr = '0, sfrWdata = '0, sfrRdata;
  logic [2:0]  opKind = '0;
  logic [7:0]  workReg = '0, storeData = '0;
  logic [15:0] loadValue = '0;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, memRdata = '0, loadData;
  logic        memWe, memRe, unmappedFlag, loadValid;
  logic [1:0]  memRegion;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  xdata_addr_gen uut (
    .clk(clk), .rstN(rstN), .sfrWe(sfrWe), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .sfrRdata(sfrRdata), .opKind(opKind), .workReg(workReg), .loadValue(loadValue),
    .storeData(storeData), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRe(memRe), .memRdata(memRdata), .memRegion(memRegion),
    .unmappedFlag(unmappedFlag), .loadData(loadData), .loadValid(loadValid)
  );

  // Memory model: byte derived from address, returned one cycle after memRe
  function automatic logic [7:0] pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (memRe) memRdata <= pattern(memAddr);

  function automatic logic [1:0] benchRegion(input logic [15:0] a);
    if (a < 16'd3072) return 2'd1;
    if (a >= 16'h2000 && a <= 16'h27FF) return 2'd2;
    if (a >= 16'h2800 && a <= 16'h287F) return 2'd3;
    return 2'd0;
  endfunction

  // Bench model of the register state
  logic [15:0] mPtr [2];
  logic        mSel;
  logic [7:0]  mPage;

  // Scoreboard queues
  typedef struct packed {
    logic        we, re, unm;
    logic [1:0]  region;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } memItem_t;

  memItem_t    memQ[$];
  string       memTagQ[$];
  logic [7:0]  rdQ[$];
  string       rdTagQ[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memWe || memRe || unmappedFlag) begin
        if (memQ.size() == 0) begin
          check(0, "R10 unexpected access", {memWe, memRe, unmappedFlag, memAddr}, 0);
        end else begin
          memItem_t e;
          string t;
          e = memQ.pop_front();
          t = memTagQ.pop_front();
          check({memWe, memRe, unmappedFlag, memRegion, memAddr} == {e.we, e.re, e.unm, e.region, e.addr},
                t, {11'd0, memWe, memRe, unmappedFlag, memRegion, memAddr},
                {11'd0, e.we, e.re, e.unm, e.region, e.addr});
          if (e.we) check(memWdata == e.wdata, {t, " wdata"}, memWdata, e.wdata);
        end
      end
      if (loadValid) begin
        if (rdQ.size() == 0) begin
          check(0, "R11 unexpected result", loadData, 0);
        end else begin
          logic [7:0] d;
          string t;
          d = rdQ.pop_front();
          t = rdTagQ.pop_front();
          check(loadData == d, t, loadData, d);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic doOp(input logic [2:0] k, input logic [7:0] wr, input logic [15:0] lv, input logic [7:0] sd);
    opKind = k; workReg = wr; loadValue = lv; storeData = sd;
    tick();
    opKind = 3'd0;
  endtask

  task automatic pushExp(input logic [15:0] a, input bit isWr, input logic [7:0] d, input string tag);
    memItem_t e;
    logic [1:0] r;
    r = benchRegion(a);
    e.we = isWr && (r != 0);
    e.re = !isWr && (r != 0);
    e.unm = (r == 0);
    e.region = r;
    e.addr = a;
    e.wdata = d;
    memQ.push_back(e);
    memTagQ.push_back(tag);
    if (!isWr) begin
      rdQ.push_back((r != 0) ? pattern(a) : 8'h00);
      rdTagQ.push_back({tag, " data"});
    end
  endtask

  task automatic ptrAccess(input bit isWr, input logic [7:0] d, input string tag);
    pushExp(mPtr[mSel], isWr, d, tag);
    doOp(isWr ? 3'd4 : 3'd3, 8'h00, 16'h0000, d);
  endtask

  task automatic pagedAccess(input bit isWr, input logic [7:0] wr, input logic [7:0] d, input string tag);
    pushExp({mPage, wr}, isWr, d, tag);
    doOp(isWr ? 3'd2 : 3'd1, wr, 16'h0000, d);
  endtask

  task automatic ptrLoad(input logic [15:0] v);
    mPtr[mSel] = v;
    doOp(3'd5, 8'h00, v, 8'h00);
  endtask

  task automatic ptrInc();
    mPtr[mSel] = mPtr[mSel] + 16'd1;
    doOp(3'd6, 8'h00, 16'h0000, 8'h00);
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h92: mSel = d[0];
      8'hBF: mPage = d;
      8'h82: mPtr[mSel][7:0] = d;
      8'h83: mPtr[mSel][15:8] = d;
      default: ;
    endcase
    sfrWe = 1'b1; sfrAddr = a; sfrWdata = d;
    tick();
    sfrWe = 1'b0;
  endtask

  task automatic sfrExpect(input logic [7:0] a, input logic [7:0] exp, input string tag);
    sfrAddr = a;
    #1;
    check(sfrRdata == exp, tag, sfrRdata, exp);
  endtask

  // Watchdog
  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mPtr[0] = '0; mPtr[1] = '0; mSel = 0; mPage = '0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1: reset state
    sfrExpect(8'h82, 8'h00, "R1 ptr low after reset");
    sfrExpect(8'h83, 8'h00, "R1 ptr high after reset");
    sfrExpect(8'h92, 8'h00, "R1 select after reset");
    sfrExpect(8'hBF, 8'h00, "R1 page after reset");
    check({memWe, memRe, loadValid, unmappedFlag} == 4'b0, "R1 strobes idle",
          {memWe, memRe, loadValid, unmappedFlag}, 0);
    tick();

    // R2: page register and paged accesses
    sfrWrite(8'hBF, 8'h21);
    sfrExpect(8'hBF, 8'h21, "R2 page readback");
    tick();
    pagedAccess(1'b1, 8'h34, 8'hA5, "R2 R10 paged write to config");
    sfrWrite(8'hBF, 8'h00);
    pagedAccess(1'b0, 8'h10, 8'h00, "R2 R11 paged read shared");
    pagedAccess(1'b0, 8'h11, 8'h00, "R11 back-to-back read");
    sfrWrite(8'hBF, 8'h30);
    pagedAccess(1'b0, 8'h00, 8'h00, "R9 paged read unmapped");

    // R3, R8, R9: pointer accesses across the shared edge
    ptrLoad(16'h0BFF);
    ptrAccess(1'b0, 8'h00, "R3 R8 last shared byte");
    ptrInc();
    sfrExpect(8'h82, 8'h00, "R6 inc low byte");
    sfrExpect(8'h83, 8'h0C, "R6 inc high byte");
    tick();
    ptrAccess(1'b0, 8'h00, "R9 read past shared");
    ptrAccess(1'b1, 8'h77, "R9 write suppressed");
    check(memWe == 1'b0, "R10 write strobe one cycle", memWe, 0);

    // R4, R5: select switching keeps pointers
    sfrWrite(8'h92, 8'h01);
    sfrExpect(8'h92, 8'h01, "R4 select readback");
    sfrExpect(8'h83, 8'h00, "R4 R7 secondary high is zero");
    tick();
    ptrLoad(16'h2800);
    ptrAccess(1'b1, 8'h3C, "R3 R10 battery write");
    sfrWrite(8'h92, 8'h00);
    sfrExpect(8'h82, 8'h00, "R5 primary low kept");
    sfrExpect(8'h83, 8'h0C, "R5 primary high kept");
    tick();
    sfrWrite(8'h92, 8'hFE);
    sfrExpect(8'h92, 8'h00, "R4 upper bits ignored, bit0 zero");
    tick();
    sfrWrite(8'h92, 8'hFF);
    sfrExpect(8'h92, 8'h01, "R4 upper bits read as zero");
    sfrExpect(8'h83, 8'h28, "R5 secondary kept");
    tick();

    // R6: wrap on secondary, primary untouched
    ptrLoad(16'hFFFF);
    ptrInc();
    sfrExpect(8'h82, 8'h00, "R6 wrap low");
    sfrExpect(8'h83, 8'h00, "R6 wrap high");
    tick();
    sfrWrite(8'h92, 8'h00);
    sfrExpect(8'h83, 8'h0C, "R6 other pointer untouched");
    tick();

    // R7: byte access to the active pointer
    sfrWrite(8'h92, 8'h01);
    sfrWrite(8'h83, 8'h28);
    sfrWrite(8'h82, 8'h7F);
    sfrExpect(8'h82, 8'h7F, "R7 low byte written");
    tick();
    ptrAccess(1'b0, 8'h00, "R7 R8 last battery byte");
    ptrInc();
    ptrAccess(1'b0, 8'h00, "R8 R9 past battery");
    sfrWrite(8'h92, 8'h00);
    sfrExpect(8'h82, 8'h00, "R7 primary low unaffected");
    tick();

    // R8: config edges
    ptrLoad(16'h27FF);
    ptrAccess(1'b0, 8'h00, "R8 last config byte");
    ptrLoad(16'h1FFF);
    ptrAccess(1'b1, 8'h11, "R8 R9 gap write");
    ptrLoad(16'h2000);
    ptrAccess(1'b1, 8'h99, "R8 R10 first config byte");

    repeat (4) tick();
    check(memQ.size() == 0, "R10 all accesses seen", memQ.size(), 0);
    check(rdQ.size() == 0, "R11 all results seen", rdQ.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule